// File: doc/BRIEF.md
# Processor Status Word Register

This block keeps the status word of a 16-bit minicomputer-style processor: the four condition flags, the trace bit, a three-bit interrupt priority, a register-set select bit, and two-bit previous-mode and current-mode fields. The word can change in five ways. A trap strobe loads a new word taken from a vector. A privileged load replaces every field. A memory-mapped write also replaces every field, but first folds the current mode into the previous-mode field. A restricted load can only raise the mode and register-set fields. A condition-code write touches only the four flags.

The block also keeps one saved stack pointer for each processor mode. When the current mode changes, the live stack pointer is stored into the slot of the mode being left, and the slot of the mode being entered becomes live. On each trap, the word that was in force before the trap is held on a separate output so that the surrounding core can push it. When the register-set select changes, the block gives a one-cycle pulse so that the core can swap its general register bank.

Every update is registered and shows on the outputs one clock after its strobe.

Top module: `psw_unit`

## Requirements
- R1: While reset is asserted, the status word, the push word, the swap pulse, the live stack pointer and every saved stack-pointer slot are forced to zero. This selects kernel mode 0, priority 0 and register set 0.
- R2: A privileged load replaces every field from `ld_word`. The field positions are: C at bit 0, V at bit 1, Z at bit 2, N at bit 3, T at bit 4, priority at bits 7:5, register set at bit 11, previous mode at bits 13:12 and current mode at bits 15:14. Bits 10:8 always read as 0.
- R3: A restricted load takes the four flags and T from `ld_word`. It ORs the register-set, previous-mode and current-mode fields with the incoming values and leaves the priority unchanged.
- R4: A current-mode value of 2 that results from any load is stored as 3, so `cur_mode` never reads 2.
- R5: Each mode has its own saved stack pointer. On a change of current mode, the live value is saved into the slot of the outgoing mode and the slot of the incoming mode becomes live. If `sp_wr` is asserted in the same cycle, its data is the value that gets saved. Without a mode change, `sp_wr` updates the live value, and without `sp_wr` the live value holds.
- R6: A trap strobe loads `trap_word` with the current mode ORed into bits 13:12. `push_word` then holds the status word as it stood before the trap.
- R7: A memory-mapped write loads `wr_word` with the current mode ORed into bits 13:12. The register-set bit is taken from bit 11 of `wr_word`.
- R8: `rs_swap` is high for exactly the cycle after an update that changes the register-set bit. It stays low when the register-set bit is written with its present value.
- R9: A condition-code write sets N, Z, V and C from bits 3, 2, 1 and 0 of `cc_word` and leaves all other fields unchanged.
- R10: When several strobes are asserted in the same cycle, only one takes effect, in this order of precedence: trap, then privileged load, then memory-mapped write, then restricted load, then condition-code write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| trap_ld | input | 1 | Trap entry strobe |
| full_ld | input | 1 | Privileged load strobe |
| mm_wr | input | 1 | Memory-mapped write strobe |
| lim_ld | input | 1 | Restricted load strobe |
| cc_wr | input | 1 | Condition-code write strobe |
| trap_word | input | 16 | Status word taken from the trap vector |
| ld_word | input | 16 | Data for privileged and restricted loads |
| wr_word | input | 16 | Data for the memory-mapped write |
| cc_word | input | 4 | New N, Z, V and C flags |
| sp_wr | input | 1 | Live stack-pointer write strobe |
| sp_wdata | input | 16 | Live stack-pointer write data |
| psw | output | 16 | Assembled status word |
| cur_mode | output | 2 | Current processor mode |
| prio | output | 3 | Interrupt priority |
| sp | output | 16 | Live stack pointer for the current mode |
| push_word | output | 16 | Status word saved by the last trap |
| rs_swap | output | 1 | One-cycle pulse on a register-set change |

## Verification
The embedded properties assume that strobes are sampled only on clock edges and that an update takes effect only through the fixed precedence order. For example, the restricted-load checks apply only when no stronger strobe is active in the same cycle. The stimulus drives all strobes and data on the falling edge, holds each for one cycle and checks the result on the next falling edge. Strobes overlap only in the dedicated precedence cases, whose expected winner is stated in R10. The stack-pointer tests start from a fresh reset, so the contents of every slot are known, and they include a write that coincides with a mode change.

// File: rtl/psw_pkg.sv
package psw_pkg;

   typedef struct packed {
      logic [1:0] cm;
      logic [1:0] pm;
      logic       rs;
      logic [2:0] rsv;
      logic [2:0] prio;
      logic       t;
      logic       n;
      logic       z;
      logic       v;
      logic       c;
   } psw_t;

   typedef enum logic [2:0] {
      UPD_NONE,
      UPD_TRAP,
      UPD_FULL,
      UPD_MM,
      UPD_LIM,
      UPD_CC
   } upd_kind_e;

endpackage

// File: rtl/psw_next.sv
module psw_next
   import psw_pkg::*;
#(
   parameter bit MODE2_AS_3 = 1'b1
) (
   input  psw_t       cur,
   input  upd_kind_e  kind,
   input  logic [15:0] ld_word,
   input  logic [15:0] wr_word,
   input  logic [15:0] trap_word,
   input  logic [3:0]  cc_word,
   output psw_t       nxt
);

   psw_t raw;
   psw_t w_ld;
   psw_t w_mm;
   psw_t w_trap;

   always_comb begin
      w_ld   = psw_t'(ld_word);
      w_mm   = psw_t'(wr_word | {2'b00, cur.cm, 12'h000});
      w_trap = psw_t'(trap_word | {2'b00, cur.cm, 12'h000});
   end

   always_comb begin
      raw = cur;
      unique case (kind)
         UPD_TRAP: raw = w_trap;
         UPD_FULL: raw = w_ld;
         UPD_MM: begin
            raw    = w_mm;
            raw.rs = wr_word[11];
         end
         UPD_LIM: begin
            raw.c  = w_ld.c;
            raw.v  = w_ld.v;
            raw.z  = w_ld.z;
            raw.n  = w_ld.n;
            raw.t  = w_ld.t;
            raw.rs = cur.rs | w_ld.rs;
            raw.pm = cur.pm | w_ld.pm;
            raw.cm = cur.cm | w_ld.cm;
         end
         UPD_CC: begin
            raw.n = cc_word[3];
            raw.z = cc_word[2];
            raw.v = cc_word[1];
            raw.c = cc_word[0];
         end
         default: raw = cur;
      endcase
      raw.rsv = 3'b000;
   end

   generate
      if (MODE2_AS_3) begin : g_remap
         always_comb begin
            nxt = raw;
            if (raw.cm == 2'd2) nxt.cm = 2'd3;
         end
      end else begin : g_plain
         always_comb nxt = raw;
      end
   endgenerate

endmodule

// File: rtl/psw_sp_bank.sv
module psw_sp_bank #(
   parameter int SP_W      = 16,
   parameter int NUM_MODES = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [$clog2(NUM_MODES)-1:0]   cur_mode,
   input  logic [$clog2(NUM_MODES)-1:0]   nxt_mode,
   input  logic                           sp_wr,
   input  logic [SP_W-1:0]                sp_wdata,
   output logic [SP_W-1:0]                sp
);

   localparam int MODE_W = $clog2(NUM_MODES);

   generate
      if (NUM_MODES < 2 || (1 << MODE_W) != NUM_MODES) begin : g_bad_modes
         $error("psw_sp_bank: NUM_MODES must be a power of two of at least 2");
      end
      if (SP_W < 1) begin : g_bad_width
         $error("psw_sp_bank: SP_W must be positive");
      end
   endgenerate

   logic [SP_W-1:0] slot [NUM_MODES];
   logic [SP_W-1:0] sp_q;
   logic [SP_W-1:0] save_val;
   logic            chg;

   assign chg      = (nxt_mode != cur_mode);
   assign save_val = sp_wr ? sp_wdata : sp_q;

   generate
      for (genvar g = 0; g < NUM_MODES; g++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               slot[g] <= '0;
            end else if (chg && cur_mode == MODE_W'(g)) begin
               slot[g] <= save_val;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp_q <= '0;
      end else if (chg) begin
         sp_q <= slot[nxt_mode];
      end else if (sp_wr) begin
         sp_q <= sp_wdata;
      end
   end

   assign sp = sp_q;

   // R5: with no mode change and no write, the live pointer holds
   p_sp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!chg && !sp_wr) |=> $stable(sp_q));

   // R5: a plain write without a mode change lands in the live pointer
   p_sp_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!chg && sp_wr) |=> (sp_q == $past(sp_wdata)));

endmodule

// File: rtl/psw_unit.sv
module psw_unit
   import psw_pkg::*;
#(
   parameter int SP_W       = 16,
   parameter int NUM_MODES  = 4,
   parameter bit MODE2_AS_3 = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        trap_ld,
   input  logic        full_ld,
   input  logic        mm_wr,
   input  logic        lim_ld,
   input  logic        cc_wr,
   input  logic [15:0] trap_word,
   input  logic [15:0] ld_word,
   input  logic [15:0] wr_word,
   input  logic [3:0]  cc_word,
   input  logic        sp_wr,
   input  logic [15:0] sp_wdata,
   output logic [15:0] psw,
   output logic [1:0]  cur_mode,
   output logic [2:0]  prio,
   output logic [15:0] sp,
   output logic [15:0] push_word,
   output logic        rs_swap
);

   localparam int WORD_W = $bits(psw_t);

   generate
      if (WORD_W != 16) begin : g_bad_word
         $error("psw_unit: status word layout must be 16 bits");
      end
      if (SP_W != 16 || NUM_MODES != 4) begin : g_bad_cfg
         $error("psw_unit: port widths need SP_W 16 and NUM_MODES 4");
      end
   endgenerate

   psw_t      psw_q;
   psw_t      psw_d;
   upd_kind_e kind;
   logic [15:0] push_q;
   logic        swap_q;

   always_comb begin
      if (trap_ld)      kind = UPD_TRAP;
      else if (full_ld) kind = UPD_FULL;
      else if (mm_wr)   kind = UPD_MM;
      else if (lim_ld)  kind = UPD_LIM;
      else if (cc_wr)   kind = UPD_CC;
      else              kind = UPD_NONE;
   end

   psw_next #(.MODE2_AS_3(MODE2_AS_3)) u_next (
      .cur       (psw_q),
      .kind      (kind),
      .ld_word   (ld_word),
      .wr_word   (wr_word),
      .trap_word (trap_word),
      .cc_word   (cc_word),
      .nxt       (psw_d)
   );

   psw_sp_bank #(.SP_W(SP_W), .NUM_MODES(NUM_MODES)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .cur_mode (psw_q.cm),
      .nxt_mode (psw_d.cm),
      .sp_wr    (sp_wr),
      .sp_wdata (sp_wdata),
      .sp       (sp)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         psw_q  <= '0;
         push_q <= '0;
         swap_q <= 1'b0;
      end else begin
         psw_q  <= psw_d;
         swap_q <= (psw_d.rs != psw_q.rs);
         if (kind == UPD_TRAP) push_q <= psw_q;
      end
   end

   assign psw       = psw_q;
   assign cur_mode  = psw_q.cm;
   assign prio      = psw_q.prio;
   assign push_word = push_q;
   assign rs_swap   = swap_q;

   // R4: the stored current mode never holds the value 2
   p_mode_not2_r4: assert property (@(posedge clk) disable iff (!rst_n)
      MODE2_AS_3 |-> (psw_q.cm != 2'd2));

   // R3: a lone restricted load keeps the priority
   p_lim_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (lim_ld && !trap_ld && !full_ld && !mm_wr) |=> $stable(psw_q.prio));

   // R3: a restricted load never clears a mode or register-set bit
   p_lim_raise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (lim_ld && !trap_ld && !full_ld && !mm_wr) |=>
      ((($past(psw_q[15:11]) & ~psw_q[15:11]) == 5'b0)));

   // R9: a lone flag write leaves bits 15:4 untouched
   p_cc_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cc_wr && !trap_ld && !full_ld && !mm_wr && !lim_ld) |=>
      $stable(psw_q[15:4]));

   // R8: a swap pulse only follows an actual register-set change
   p_swap_real_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rs_swap |-> (psw_q.rs != $past(psw_q.rs)));

   // R6: after a trap the push word carries the old status word
   p_trap_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
      trap_ld |=> (push_q == $past(psw_q)));

   // R2: the reserved bits always read as zero
   p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      psw_q.rsv == 3'b000);

endmodule

// File: tb/psw_unit_tb.sv
module psw_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trap_ld = 1'b0, full_ld = 1'b0, mm_wr = 1'b0, lim_ld = 1'b0, cc_wr = 1'b0;
   logic [15:0] trap_word = '0, ld_word = '0, wr_word = '0;
   logic [3:0]  cc_word = '0;
   logic        sp_wr = 1'b0;
   logic [15:0] sp_wdata = '0;
   logic [15:0] psw, sp, push_word;
   logic [1:0]  cur_mode;
   logic [2:0]  prio;
   logic        rs_swap;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   psw_unit u_dut (
      .clk(clk), .rst_n(rst_n),
      .trap_ld(trap_ld), .full_ld(full_ld), .mm_wr(mm_wr), .lim_ld(lim_ld), .cc_wr(cc_wr),
      .trap_word(trap_word), .ld_word(ld_word), .wr_word(wr_word), .cc_word(cc_word),
      .sp_wr(sp_wr), .sp_wdata(sp_wdata),
      .psw(psw), .cur_mode(cur_mode), .prio(prio), .sp(sp),
      .push_word(push_word), .rs_swap(rs_swap)
   );

   // op codes: 0 privileged load, 1 restricted load, 2 mm write, 3 trap, 4 flag write
   // fields: op[34:32], data[31:16], expected psw[15:0]
   localparam logic [34:0] VEC [11] = '{
      {3'd0, 16'h00EF, 16'h00EF},  // R2 all flags, priority 7
      {3'd1, 16'h4812, 16'h48F2},  // R3 mode/rs raised, priority kept
      {3'd1, 16'h8000, 16'hC8E0},  // R3 R4 1|2 -> 3
      {3'd4, 16'h0005, 16'hC8E5},  // R9 flags only
      {3'd0, 16'h0000, 16'h0000},  // R2 full replace lowers mode
      {3'd0, 16'h8000, 16'hC000},  // R4 mode 2 stored as 3
      {3'd6, 16'h0020, 16'h3020},  // R6 trap: prev mode gets 3
      {3'd2, 16'h4803, 16'h4803},  // R7 mm write from mode 0
      {3'd2, 16'h0000, 16'h1000},  // R7 current mode 1 into prev
      {3'd1, 16'h1010, 16'h1010},  // R3 prev mode ORed
      {3'd3, 16'hA000, 16'hE000}   // R6 R4 trap word with mode 2
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(input int op, input logic [15:0] d);
      @(negedge clk);
      trap_ld = (op == 3 || op == 6);
      full_ld = (op == 0);
      mm_wr   = (op == 2);
      lim_ld  = (op == 1);
      cc_wr   = (op == 4);
      trap_word = d; ld_word = d; wr_word = d; cc_word = d[3:0];
      @(negedge clk);
      {trap_ld, full_ld, mm_wr, lim_ld, cc_wr} = '0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      do_reset();
      chk("R1 psw", psw, 16'h0000);
      chk("R1 sp", sp, 16'h0000);
      chk("R1 push", push_word, 16'h0000);

      for (int i = 0; i < 11; i++) begin
         step(int'(VEC[i][34:32]), VEC[i][31:16]);
         chk($sformatf("R2/R3/R4/R6/R7/R9 vector %0d", i), psw, VEC[i][15:0]);
      end
      chk("R6 push word after trap", push_word, 16'h1010);
      chk("R4 cur_mode port", {14'b0, cur_mode}, 16'h0003);

      // R2 reserved bits read zero and priority port
      step(0, 16'h07A0);
      chk("R2 reserved bits", psw, 16'h00A0);
      chk("R2 priority port", {13'b0, prio}, 16'h0005);

      // R8 register-set swap pulse
      step(0, 16'h0800);
      chk("R8 pulse on change", {15'b0, rs_swap}, 16'h0001);
      step(0, 16'h0800);
      chk("R8 no pulse same value", {15'b0, rs_swap}, 16'h0000);
      step(1, 16'h0000);
      chk("R8 restricted keeps rs", {15'b0, rs_swap}, 16'h0000);
      chk("R3 rs not cleared", psw, 16'h0800);

      // R10 precedence: trap over privileged load
      @(negedge clk);
      trap_ld = 1'b1; full_ld = 1'b1; trap_word = 16'h0040; ld_word = 16'h00FF;
      @(negedge clk);
      {trap_ld, full_ld} = '0;
      chk("R10 trap wins", psw, 16'h0040);
      chk("R6 push old word", push_word, 16'h0800);
      // R10 restricted load over flag write
      @(negedge clk);
      lim_ld = 1'b1; cc_wr = 1'b1; ld_word = 16'h0001; cc_word = 4'hE;
      @(negedge clk);
      {lim_ld, cc_wr} = '0;
      chk("R10 restricted wins over flags", psw, 16'h0041);
      // R10 mm write over restricted load
      @(negedge clk);
      mm_wr = 1'b1; lim_ld = 1'b1; wr_word = 16'h0002; ld_word = 16'h4000;
      @(negedge clk);
      {mm_wr, lim_ld} = '0;
      chk("R10 mm wins over restricted", psw, 16'h0002);

      // R5 stack pointer banking from a fresh reset
      do_reset();
      chk("R1 psw after second reset", psw, 16'h0000);
      @(negedge clk); sp_wr = 1'b1; sp_wdata = 16'h1111;
      @(negedge clk); sp_wr = 1'b0;
      chk("R5 live write", sp, 16'h1111);
      step(0, 16'h4000);
      chk("R5 mode 1 slot empty", sp, 16'h0000);
      @(negedge clk); sp_wr = 1'b1; sp_wdata = 16'h2222;
      @(negedge clk); sp_wr = 1'b0;
      step(0, 16'hC000);
      chk("R5 mode 3 slot empty", sp, 16'h0000);
      @(negedge clk); sp_wr = 1'b1; sp_wdata = 16'h3333;
      @(negedge clk); sp_wr = 1'b0;
      step(0, 16'h0000);
      chk("R5 back to mode 0", sp, 16'h1111);
      step(0, 16'h4000);
      chk("R5 back to mode 1", sp, 16'h2222);
      step(0, 16'h8000);
      chk("R5 mode 2 uses slot 3", sp, 16'h3333);
      step(0, 16'hC0FF);
      chk("R5 same mode keeps sp", sp, 16'h3333);
      @(negedge clk);
      full_ld = 1'b1; ld_word = 16'h0000; sp_wr = 1'b1; sp_wdata = 16'h4444;
      @(negedge clk);
      full_ld = 1'b0; sp_wr = 1'b0;
      chk("R5 switch with write", sp, 16'h1111);
      step(0, 16'hC000);
      chk("R5 write saved on switch", sp, 16'h4444);

      // R1 reset from a busy state
      do_reset();
      chk("R1 psw cleared", psw, 16'h0000);
      chk("R1 sp cleared", sp, 16'h0000);
      step(0, 16'hC000);
      chk("R1 slots cleared", sp, 16'h0000);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule